// File: doc/BRIEF.md
# Segment-Based Address Translator

This block is the first stage of a 32-bit memory management unit. For every accepted access it chooses one of three outcomes. If translation is switched off, the address passes through unchanged. If the segment selected by the top address bits is marked for direct mapping, a 4-bit physical base replaces the top nibble. Otherwise the access is handed to a paged lookup path, and the block waits for its result.

The sixteen segment bases are packed as nibbles into two 32-bit base words. The low word serves segments 0 to 7 and the high word serves segments 8 to 15. On a paged hand-off the block presents the virtual page number, the access type, the privilege mode and a flag that steers the lookup to the instruction or the data table. It then returns the frame number shifted into place together with the miss flag and permissions reported by that path.

Requests are accepted only while the block is idle. The result appears as a one-cycle valid pulse with a registered address, permissions, miss flag and outcome kind.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rsp_valid_o` and `tlb_req_o` are 0 and `req_ready_o` is 1.
- R2: When bits 2 and 3 of `glb_cfg_i` are both 0, an accepted request responds on the next cycle with `rsp_paddr_o` equal to `vaddr_i`, `rsp_perm_o` = 3'b111, `rsp_miss_o` = 0 and `rsp_kind_o` = 0. The other bits of `glb_cfg_i` have no effect.
- R3: With translation on (bit 2 or bit 3 of `glb_cfg_i` set), a request is direct-mapped exactly when bit N of `seg_map_i` is 1, where N is `vaddr_i[31:28]`. Otherwise it takes the paged path.
- R4: A direct-mapped result has `rsp_paddr_o` = {base nibble, `vaddr_i[27:0]`} and `rsp_kind_o` = 1. The base nibble is bits [4k+3:4k] of `seg_base_lo_i` for segment N < 8, or of `seg_base_hi_i` for N >= 8, where k = N mod 8.
- R5: A direct-mapped result appears one cycle after acceptance, with `rsp_perm_o` = 3'b111 and `rsp_miss_o` = 0.
- R6: A paged request raises `tlb_req_o` one cycle after acceptance, with `tlb_vpn_o` = `vaddr_i[31:13]` and the access type and mode as accepted. `tlb_req_o` stays high and `req_ready_o` stays low until a cycle with `tlb_rsp_valid_i` = 1.
- R7: The access type is encoded 0 read, 1 write, 2 execute. `tlb_instr_o` is 1 only for type 2. Types 0, 1 and 3 go to the data table.
- R8: One cycle after `tlb_rsp_valid_i` the block responds with `rsp_paddr_o` = {`tlb_pfn_i`, 13'b0}, `rsp_miss_o` = `tlb_miss_i`, `rsp_perm_o` = `tlb_perm_i` and `rsp_kind_o` = 2. `rsp_perm_o` bit 0 is read, bit 1 write, bit 2 execute.
- R9: `req_valid_i` while `req_ready_o` is 0 is ignored: it produces no response and leaves `tlb_vpn_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Block idle, request will be taken |
| vaddr_i | input | 32 | Virtual address |
| acc_type_i | input | 2 | 0 read, 1 write, 2 execute |
| user_i | input | 1 | 1 for user mode |
| glb_cfg_i | input | 32 | Global configuration word |
| seg_map_i | input | 16 | Direct-mapped segment flags |
| seg_base_lo_i | input | 32 | Bases of segments 0-7 |
| seg_base_hi_i | input | 32 | Bases of segments 8-15 |
| tlb_req_o | output | 1 | Paged lookup request, held until answered |
| tlb_instr_o | output | 1 | 1 selects the instruction table |
| tlb_vpn_o | output | 19 | Virtual page number |
| tlb_acc_o | output | 2 | Access type of the lookup |
| tlb_user_o | output | 1 | Mode of the lookup |
| tlb_rsp_valid_i | input | 1 | Paged result valid |
| tlb_pfn_i | input | 19 | Page frame number |
| tlb_miss_i | input | 1 | Paged lookup missed |
| tlb_perm_i | input | 3 | Paged permissions |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_perm_o | output | 3 | Permissions (read, write, execute) |
| rsp_miss_o | output | 1 | Miss flag |
| rsp_kind_o | output | 2 | 0 identity, 1 segment, 2 paged |

## Verification
The translator is first driven with translation disabled, using global words whose other bits are all ones, so identity can be told apart from a wrongly decoded enable. It then walks all sixteen segments with every segment direct-mapped, using distinct nibbles in both base words, which exposes a wrong nibble index or a swapped word. A sparse segment map mixed with every access type then separates direct from paged routing and instruction from data steering. A stray request issued while a paged lookup is pending shows that the busy state drops it.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        KIND_IDENT = 2'd0,
        KIND_SEG   = 2'd1,
        KIND_PAGED = 2'd2
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } st_e;

    localparam int unsigned CFG_W = 32;
    // Global-config bits that switch translation on.
    localparam logic [CFG_W-1:0] XLATE_ON_MASK = 32'h0000_000C;
    localparam logic [2:0] PERM_ALL = 3'b111;

endpackage

// File: rtl/seg_route_decode.sv
module seg_route_decode
    import seg_xlate_pkg::*;
#(
    parameter int unsigned SEG_BITS = 4,
    localparam int unsigned SEG_COUNT = 1 << SEG_BITS
) (
    input  logic [CFG_W-1:0]     glb_cfg_i,
    input  logic [SEG_COUNT-1:0] seg_map_i,
    input  logic [SEG_BITS-1:0]  seg_i,
    input  logic [1:0]           acc_i,
    output logic                 xlate_on_o,
    output logic                 direct_o,
    output logic                 instr_o
);
    always_comb begin
        xlate_on_o = (glb_cfg_i & XLATE_ON_MASK) != '0;
        direct_o   = seg_map_i[seg_i];
        instr_o    = (acc_i == ACC_EXEC);
    end
endmodule

// File: rtl/seg_base_pick.sv
module seg_base_pick #(
    parameter int unsigned SEG_BITS = 4,
    localparam int unsigned SEG_COUNT = 1 << SEG_BITS,
    localparam int unsigned HALF      = SEG_COUNT / 2,
    localparam int unsigned BASE_W    = HALF * SEG_BITS
) (
    input  logic [SEG_BITS-1:0] seg_i,
    input  logic [BASE_W-1:0]   base_lo_i,
    input  logic [BASE_W-1:0]   base_hi_i,
    output logic [SEG_BITS-1:0] base_o
);
    logic [SEG_BITS-1:0] cand [SEG_COUNT];

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
        if (g < HALF) begin : g_lo
            assign cand[g] = base_lo_i[g*SEG_BITS +: SEG_BITS];
        end else begin : g_hi
            assign cand[g] = base_hi_i[(g-HALF)*SEG_BITS +: SEG_BITS];
        end
    end

    assign base_o = cand[seg_i];
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned SEG_BITS   = 4,
    parameter int unsigned PAGE_SHIFT = 13,
    localparam int unsigned SEG_COUNT = 1 << SEG_BITS,
    localparam int unsigned BASE_W    = (SEG_COUNT / 2) * SEG_BITS,
    localparam int unsigned PFN_W     = ADDR_W - PAGE_SHIFT,
    localparam int unsigned OFS_W     = ADDR_W - SEG_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    output logic                 req_ready_o,
    input  logic [ADDR_W-1:0]    vaddr_i,
    input  logic [1:0]           acc_type_i,
    input  logic                 user_i,
    input  logic [CFG_W-1:0]     glb_cfg_i,
    input  logic [SEG_COUNT-1:0] seg_map_i,
    input  logic [BASE_W-1:0]    seg_base_lo_i,
    input  logic [BASE_W-1:0]    seg_base_hi_i,
    output logic                 tlb_req_o,
    output logic                 tlb_instr_o,
    output logic [PFN_W-1:0]     tlb_vpn_o,
    output logic [1:0]           tlb_acc_o,
    output logic                 tlb_user_o,
    input  logic                 tlb_rsp_valid_i,
    input  logic [PFN_W-1:0]     tlb_pfn_i,
    input  logic                 tlb_miss_i,
    input  logic [2:0]           tlb_perm_i,
    output logic                 rsp_valid_o,
    output logic [ADDR_W-1:0]    rsp_paddr_o,
    output logic [2:0]           rsp_perm_o,
    output logic                 rsp_miss_o,
    output logic [1:0]           rsp_kind_o
);

    typedef struct packed {
        st_e               st;
        logic              rsp_valid;
        logic [ADDR_W-1:0] paddr;
        logic [2:0]        perm;
        logic              miss;
        kind_e             kind;
        logic              tlb_req;
        logic              tlb_instr;
        logic [PFN_W-1:0]  vpn;
        logic [1:0]        acc;
        logic              user;
    } state_t;

    state_t state_d, state_q;

    logic                xlate_on, direct, instr;
    logic [SEG_BITS-1:0] seg_base;

    seg_route_decode #(.SEG_BITS(SEG_BITS)) u_decode (
        .glb_cfg_i  (glb_cfg_i),
        .seg_map_i  (seg_map_i),
        .seg_i      (vaddr_i[ADDR_W-1 -: SEG_BITS]),
        .acc_i      (acc_type_i),
        .xlate_on_o (xlate_on),
        .direct_o   (direct),
        .instr_o    (instr)
    );

    seg_base_pick #(.SEG_BITS(SEG_BITS)) u_base (
        .seg_i     (vaddr_i[ADDR_W-1 -: SEG_BITS]),
        .base_lo_i (seg_base_lo_i),
        .base_hi_i (seg_base_hi_i),
        .base_o    (seg_base)
    );

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = 1'b0;
        unique case (state_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (!xlate_on) begin
                        state_d.rsp_valid = 1'b1;
                        state_d.paddr     = vaddr_i;
                        state_d.perm      = PERM_ALL;
                        state_d.miss      = 1'b0;
                        state_d.kind      = KIND_IDENT;
                    end else if (direct) begin
                        state_d.rsp_valid = 1'b1;
                        state_d.paddr     = {seg_base, vaddr_i[OFS_W-1:0]};
                        state_d.perm      = PERM_ALL;
                        state_d.miss      = 1'b0;
                        state_d.kind      = KIND_SEG;
                    end else begin
                        state_d.st        = ST_WAIT;
                        state_d.tlb_req   = 1'b1;
                        state_d.tlb_instr = instr;
                        state_d.vpn       = vaddr_i[ADDR_W-1:PAGE_SHIFT];
                        state_d.acc       = acc_type_i;
                        state_d.user      = user_i;
                    end
                end
            end
            ST_WAIT: begin
                if (tlb_rsp_valid_i) begin
                    state_d.st        = ST_IDLE;
                    state_d.tlb_req   = 1'b0;
                    state_d.rsp_valid = 1'b1;
                    state_d.paddr     = {tlb_pfn_i, {PAGE_SHIFT{1'b0}}};
                    state_d.perm      = tlb_perm_i;
                    state_d.miss      = tlb_miss_i;
                    state_d.kind      = KIND_PAGED;
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.st   <= ST_IDLE;
            state_q.kind <= KIND_IDENT;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_ready_o = (state_q.st == ST_IDLE);
    assign tlb_req_o   = state_q.tlb_req;
    assign tlb_instr_o = state_q.tlb_instr;
    assign tlb_vpn_o   = state_q.vpn;
    assign tlb_acc_o   = state_q.acc;
    assign tlb_user_o  = state_q.user;
    assign rsp_valid_o = state_q.rsp_valid;
    assign rsp_paddr_o = state_q.paddr;
    assign rsp_perm_o  = state_q.perm;
    assign rsp_miss_o  = state_q.miss;
    assign rsp_kind_o  = state_q.kind;

    assert_ident_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_kind_o == KIND_IDENT |->
            rsp_paddr_o == $past(vaddr_i) && rsp_perm_o == PERM_ALL && !rsp_miss_o);

    assert_seg_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_kind_o == KIND_SEG |->
            rsp_paddr_o[OFS_W-1:0] == $past(vaddr_i[OFS_W-1:0]) &&
            rsp_perm_o == PERM_ALL && !rsp_miss_o);

    assert_tlb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req_o && !tlb_rsp_valid_i |=> tlb_req_o && $stable(tlb_vpn_o) && !req_ready_o);

    assert_tlb_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req_o |-> tlb_instr_o == (tlb_acc_o == ACC_EXEC));

    assert_paged_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req_o && tlb_rsp_valid_i |=>
            rsp_valid_o && rsp_kind_o == KIND_PAGED && rsp_paddr_o[PAGE_SHIFT-1:0] == '0);

    assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !tlb_req_o);

endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [31:0] vaddr_i = '0;
    logic [1:0]  acc_type_i = '0;
    logic        user_i = 1'b0;
    logic [31:0] glb_cfg_i = '0;
    logic [15:0] seg_map_i = '0;
    logic [31:0] seg_base_lo_i = '0;
    logic [31:0] seg_base_hi_i = '0;
    logic        tlb_req_o, tlb_instr_o, tlb_user_o;
    logic [18:0] tlb_vpn_o;
    logic [1:0]  tlb_acc_o;
    logic        tlb_rsp_valid_i = 1'b0;
    logic [18:0] tlb_pfn_i = '0;
    logic        tlb_miss_i = 1'b0;
    logic [2:0]  tlb_perm_i = '0;
    logic        rsp_valid_o, rsp_miss_o;
    logic [31:0] rsp_paddr_o;
    logic [2:0]  rsp_perm_o;
    logic [1:0]  rsp_kind_o;

    always #10 clk = ~clk;

    seg_xlate u_seg_xlate (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [37:0] sb_q [$];

    logic [18:0] exp_vpn;
    logic        exp_instr, exp_user;
    logic [1:0]  exp_acc;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Paged responder behaviour, a function of the page number.
    function automatic logic [18:0] tlb_pfn_of(logic [18:0] v);
        return v ^ 19'h2A5A5;
    endfunction

    function automatic logic [37:0] model(logic [31:0] va);
        logic [3:0]  seg;
        logic [3:0]  nib;
        logic [31:0] w;
        seg = va[31:28];
        if ((glb_cfg_i[2] | glb_cfg_i[3]) == 1'b0)
            return {va, 3'b111, 1'b0, 2'd0};
        if (seg_map_i[seg]) begin
            w   = seg[3] ? seg_base_hi_i : seg_base_lo_i;
            nib = w[seg[2:0]*4 +: 4];
            return {nib, va[27:0], 3'b111, 1'b0, 2'd1};
        end
        return {tlb_pfn_of(va[31:13]), 13'b0, va[16:14], va[13], 2'd2};
    endfunction

    task automatic send(logic [31:0] va, logic [1:0] acc, logic usr);
        logic [37:0] e;
        while (!req_ready_o) @(negedge clk);
        vaddr_i    = va;
        acc_type_i = acc;
        user_i     = usr;
        e = model(va);
        sb_q.push_back(e);
        if (e[1:0] == 2'd2) begin
            exp_vpn   = va[31:13];
            exp_instr = (acc == 2'd2);
            exp_user  = usr;
            exp_acc   = acc;
        end
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        if (e[1:0] == 2'd2) begin
            check("R6 tlb_req one cycle after accept", tlb_req_o, 1);
            check("R6 ready low while pending", req_ready_o, 0);
        end
    endtask

    // TLB responder
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tlb_req_o) begin
                check("R6 vpn", tlb_vpn_o, exp_vpn);
                check("R6 user", tlb_user_o, exp_user);
                check("R6 acc", tlb_acc_o, exp_acc);
                check("R7 instr route", tlb_instr_o, exp_instr);
                for (int i = 0; i < 2; i++) begin
                    @(negedge clk);
                    check("R6 tlb_req held", tlb_req_o, 1);
                    check("R9 vpn unchanged while busy", tlb_vpn_o, exp_vpn);
                end
                tlb_pfn_i       = tlb_pfn_of(tlb_vpn_o);
                tlb_miss_i      = tlb_vpn_o[0];
                tlb_perm_i      = tlb_vpn_o[3:1];
                tlb_rsp_valid_i = 1'b1;
                @(negedge clk);
                tlb_rsp_valid_i = 1'b0;
            end
        end
    end

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid_o) begin
                if (sb_q.size() == 0) begin
                    check("R9 unexpected response", 1, 0);
                end else begin
                    logic [37:0] e;
                    e = sb_q.pop_front();
                    case (e[1:0])
                        2'd0: check("R2 identity", {rsp_paddr_o, rsp_perm_o, rsp_miss_o, rsp_kind_o}, e);
                        2'd1: check("R4 R5 segment", {rsp_paddr_o, rsp_perm_o, rsp_miss_o, rsp_kind_o}, e);
                        default: check("R8 paged", {rsp_paddr_o, rsp_perm_o, rsp_miss_o, rsp_kind_o}, e);
                    endcase
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", rsp_valid_o, 0);
        check("R1 tlb_req after reset", tlb_req_o, 0);
        check("R1 ready after reset", req_ready_o, 1);

        // R2: translation off, other config bits set
        glb_cfg_i = 32'hFFFF_FFF3;
        seg_map_i = 16'hFFFF;
        send(32'h8123_4567, 2'd0, 1'b0);
        send(32'hF000_1FFF, 2'd2, 1'b1);
        glb_cfg_i = 32'h0;
        send(32'h0000_0000, 2'd1, 1'b0);
        send(32'hDEAD_BEEF, 2'd3, 1'b1);

        // R3 R4 R5: every segment direct-mapped
        glb_cfg_i     = 32'h0000_0004;
        seg_base_lo_i = 32'h9C2E_5A71;
        seg_base_hi_i = 32'h3B6F_0D84;
        for (int s = 0; s < 16; s++)
            send({s[3:0], 28'h0ABC_DEF} ^ {4'h0, s[3:0], 24'h5A5A5A}, s[1:0], s[0]);

        // R3 R7 R8: sparse map, mixed direct and paged, all access types
        glb_cfg_i = 32'h0000_0008;
        seg_map_i = 16'hA5A5;
        for (int s = 0; s < 16; s++)
            send({s[3:0], 4'h3, s[3:0], 20'h1E2D3} + (s << 13), s[1:0] ^ s[3:2], s[2]);

        // R9: stray request while a paged lookup is pending
        seg_map_i = 16'h0000;
        send(32'h4567_A000, 2'd1, 1'b1);
        glb_cfg_i   = 32'h0;
        vaddr_i     = 32'h1111_2222;
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        glb_cfg_i   = 32'h0000_000C;

        // R7: reserved access type goes to data table
        send(32'h7654_3000, 2'd3, 1'b0);
        send(32'h2222_E000, 2'd2, 1'b0);

        repeat (20) @(negedge clk);
        check("R9 scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule